// File: doc/BRIEF.md
# LCD Power-Saver Mode Controller

This block is the command-driven power-state controller of a dot-matrix LCD driver. It watches the host command byte stream and tracks several settings: whether the display is on, whether the static indicator is on, and which of the three LCD supply circuits are enabled. It also tracks a private test state. From these it keeps one of three modes, normal, sleep or standby. It drives the oscillator enable, the supply-circuit enables, the duty-drive and static-drive enables, a force-to-VDD level for the segment and common outputs, and an active-low blanking output.

Power saving is entered through a compound sequence. An all-points-on byte that arrives while the display is off puts the block in sleep if the static indicator is off, or in standby if it is on. An all-points-off byte returns the block to normal. The stored supply enables and the other settings are kept through power saving, so leaving it restores the previous supply state without any reprogramming.

Top module: `lcd_psave_ctrl`

## Requirements
- R1: After the asynchronous reset the block is in normal mode with display off, static indicator off, supply bits 000 and test state clear. The outputs are then osc_en_o=1, pwr_en_o=000, duty_en_o=1, static_en_o=0, force_vdd_o=0, blank_no=1.
- R2: A byte 00101xyz sets the stored supply bits: bit 2 booster, bit 1 regulator, bit 0 follower. In normal mode pwr_en_o equals those bits (pwr_en_o[2] booster, [1] regulator, [0] follower) from the cycle after the byte.
- R3: 0xA5 (all points on) enters power saving only when the display is off (0xAE turns it off, 0xAF turns it on). With the display on, 0xA5 leaves the mode at normal.
- R4: Sleep outputs: osc_en_o=0, pwr_en_o=000, duty_en_o=0, static_en_o=0, force_vdd_o=1, blank_no=0.
- R5: Standby, entered when the static indicator is on at entry, gives these outputs: osc_en_o=1, pwr_en_o=000, duty_en_o=0, static_en_o=1, force_vdd_o=1, blank_no=0.
- R6: 0xA4 (all points off) returns to normal mode. pwr_en_o then shows the stored supply bits again.
- R7: The reset command 0xE2 moves standby to sleep. In normal mode it changes no output.
- R8: 0xAC (indicator off) and 0xAD (indicator on) are two-byte commands. The byte that follows is an operand and is never decoded as a command.
- R9: A byte with high nibble 1111 sets the test state. While it is set, every byte except 0xE2 and 0xE3 (NOP) is ignored. Either of those two clears the test state, and 0xE2 still acts as the reset command. The hardware reset also clears it.
- R10: A supply-bit byte received during power saving updates the stored bits, while pwr_en_o stays 000.
- R11: In normal mode static_en_o follows the stored indicator setting.
- R12: With cmd_valid_i low, cmd_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid_i | input | 1 | Command byte strobe, one byte per cycle |
| cmd_i | input | 8 | Command byte |
| osc_en_o | output | 1 | Oscillator enable |
| pwr_en_o | output | 3 | Effective booster/regulator/follower enables |
| duty_en_o | output | 1 | Duty-drive circuit enable |
| static_en_o | output | 1 | Static indicator drive enable |
| force_vdd_o | output | 1 | Force segment and common outputs to VDD |
| blank_no | output | 1 | Active-low blanking, low during power saving |

## Verification
The entry sequence is tried twice, once with the display on and once with it off, to show that only the compound condition enters power saving. It is also tried with the indicator off and on, which separates sleep from standby. The supply bits are written with several distinct patterns before, during and after power saving, which shows that each bit maps to the correct enable and that the stored value survives a sleep. The command stream also places 0xA5 as an indicator operand and inside the test state, to prove that bytes in those positions are not decoded. The reset command is sent both in standby and in normal mode to show that only standby reacts.

// File: rtl/lcdps_pkg.sv
package lcdps_pkg;
  localparam int CMD_W = 8;
  localparam int PWR_W = 3;

  localparam logic [CMD_W-1:0] C_DISP_OFF = 8'hAE;
  localparam logic [CMD_W-1:0] C_DISP_ON  = 8'hAF;
  localparam logic [CMD_W-1:0] C_AP_OFF   = 8'hA4;
  localparam logic [CMD_W-1:0] C_AP_ON    = 8'hA5;
  localparam logic [CMD_W-1:0] C_STAT_OFF = 8'hAC;
  localparam logic [CMD_W-1:0] C_STAT_ON  = 8'hAD;
  localparam logic [CMD_W-1:0] C_RESET    = 8'hE2;
  localparam logic [CMD_W-1:0] C_NOP      = 8'hE3;
  localparam logic [CMD_W-PWR_W-1:0] C_PWR_HI  = 5'b00101;
  localparam logic [3:0]             C_TEST_HI = 4'hF;

  typedef enum logic [3:0] {
    OP_NONE, OP_DISP_OFF, OP_DISP_ON, OP_AP_ON, OP_AP_OFF,
    OP_STAT_OFF, OP_STAT_ON, OP_RESET, OP_NOP, OP_PWR, OP_TEST
  } op_e;

  typedef enum logic [1:0] {
    M_NORMAL  = 2'd0,
    M_SLEEP   = 2'd1,
    M_STANDBY = 2'd2
  } mode_e;
endpackage

// File: rtl/lcdps_decode.sv
module lcdps_decode
  import lcdps_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             test_i,
  output op_e              op_o,
  output logic [PWR_W-1:0] pwr_bits_o
);
  logic pend_q;
  op_e  raw_op;

  always_comb begin
    raw_op = OP_NONE;
    if (cmd_i == C_DISP_OFF)                    raw_op = OP_DISP_OFF;
    else if (cmd_i == C_DISP_ON)                raw_op = OP_DISP_ON;
    else if (cmd_i == C_AP_ON)                  raw_op = OP_AP_ON;
    else if (cmd_i == C_AP_OFF)                 raw_op = OP_AP_OFF;
    else if (cmd_i == C_STAT_OFF)               raw_op = OP_STAT_OFF;
    else if (cmd_i == C_STAT_ON)                raw_op = OP_STAT_ON;
    else if (cmd_i == C_RESET)                  raw_op = OP_RESET;
    else if (cmd_i == C_NOP)                    raw_op = OP_NOP;
    else if (cmd_i[CMD_W-1:PWR_W] == C_PWR_HI)  raw_op = OP_PWR;
    else if (cmd_i[CMD_W-1:CMD_W-4] == C_TEST_HI) raw_op = OP_TEST;
  end

  // operand bytes and test-locked bytes decode to nothing
  always_comb begin
    op_o = OP_NONE;
    if (valid_i && !pend_q) begin
      if (!test_i) op_o = raw_op;
      else if (raw_op == OP_RESET || raw_op == OP_NOP) op_o = raw_op;
    end
  end

  assign pwr_bits_o = cmd_i[PWR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (valid_i) pend_q <= !pend_q && (op_o == OP_STAT_OFF || op_o == OP_STAT_ON);
  end

  AST_OPERAND_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && valid_i) |=> !pend_q) else $error("operand"); // R8
  AST_OPERAND_NOT_DECODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> op_o == OP_NONE) else $error("operand decoded"); // R8
endmodule

// File: rtl/lcdps_mode.sv
module lcdps_mode
  import lcdps_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [PWR_W-1:0] pwr_bits_i,
  output mode_e            mode_o,
  output logic             stat_o,
  output logic [PWR_W-1:0] pwr_o,
  output logic             test_o
);
  mode_e            mode_q, mode_d;
  logic             disp_q, stat_q, test_q;
  logic [PWR_W-1:0] pwr_q;

  always_comb begin
    mode_d = mode_q;
    unique case (op_i)
      OP_AP_ON:  if (!disp_q && mode_q == M_NORMAL) mode_d = stat_q ? M_STANDBY : M_SLEEP;
      OP_AP_OFF: mode_d = M_NORMAL;
      OP_RESET:  if (mode_q == M_STANDBY) mode_d = M_SLEEP;
      default:   mode_d = mode_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_NORMAL;
      disp_q <= 1'b0;
      stat_q <= 1'b0;
      pwr_q  <= '0;
      test_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (op_i == OP_DISP_OFF) disp_q <= 1'b0;
      if (op_i == OP_DISP_ON)  disp_q <= 1'b1;
      if (op_i == OP_STAT_OFF) stat_q <= 1'b0;
      if (op_i == OP_STAT_ON)  stat_q <= 1'b1;
      if (op_i == OP_PWR)      pwr_q  <= pwr_bits_i;
      if (op_i == OP_TEST)     test_q <= 1'b1;
      else if (op_i == OP_RESET || op_i == OP_NOP) test_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign stat_o = stat_q;
  assign pwr_o  = pwr_q;
  assign test_o = test_q;

  AST_RESET_DEMOTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RESET && mode_q == M_STANDBY) |=> mode_q == M_SLEEP) else $error("demote"); // R7
  AST_ENTRY_NEEDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_NORMAL && disp_q) |=> mode_q == M_NORMAL) else $error("entry"); // R3
  AST_EXIT_ON_APOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_AP_OFF) |=> mode_q == M_NORMAL) else $error("exit"); // R6
  AST_TEST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_q && op_i != OP_RESET) |=> $stable(pwr_q) && $stable(disp_q) && $stable(stat_q))
    else $error("test lock"); // R9
endmodule

// File: rtl/lcdps_drive.sv
module lcdps_drive
  import lcdps_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             stat_i,
  input  logic [PWR_W-1:0] pwr_i,
  output logic             osc_en_o,
  output logic [PWR_W-1:0] pwr_en_o,
  output logic             duty_en_o,
  output logic             static_en_o,
  output logic             force_vdd_o,
  output logic             blank_no
);
  logic saving;
  assign saving = (mode_i != M_NORMAL);

  assign osc_en_o    = (mode_i != M_SLEEP);
  assign duty_en_o   = !saving;
  assign force_vdd_o = saving;
  assign blank_no    = !saving;
  assign static_en_o = (mode_i == M_STANDBY) || (!saving && stat_i);

  for (genvar g = 0; g < PWR_W; g++) begin : g_pwr
    assign pwr_en_o[g] = pwr_i[g] && !saving;
  end

  AST_SUPPLY_OFF_WHEN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o != '0) |-> blank_no) else $error("supply"); // R10
  AST_SLEEP_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (force_vdd_o && !static_en_o)) else $error("sleep"); // R4
endmodule

// File: rtl/lcd_psave_ctrl.sv
module lcd_psave_ctrl
  import lcdps_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             osc_en_o,
  output logic [PWR_W-1:0] pwr_en_o,
  output logic             duty_en_o,
  output logic             static_en_o,
  output logic             force_vdd_o,
  output logic             blank_no
);
  op_e              op;
  logic [PWR_W-1:0] pwr_bits, pwr_q;
  mode_e            mode;
  logic             stat, test;

  lcdps_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .test_i(test), .op_o(op), .pwr_bits_o(pwr_bits)
  );

  lcdps_mode u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .pwr_bits_i(pwr_bits),
    .mode_o(mode), .stat_o(stat), .pwr_o(pwr_q), .test_o(test)
  );

  lcdps_drive u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .stat_i(stat), .pwr_i(pwr_q),
    .osc_en_o(osc_en_o), .pwr_en_o(pwr_en_o), .duty_en_o(duty_en_o),
    .static_en_o(static_en_o), .force_vdd_o(force_vdd_o), .blank_no(blank_no)
  );

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(mode) && $stable(pwr_en_o)) else $error("idle"); // R12
endmodule

// File: tb/tb_lcd_psave_ctrl.sv
module tb_lcd_psave_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic       osc_en_o, duty_en_o, static_en_o, force_vdd_o, blank_no;
  logic [2:0] pwr_en_o;

  always #10 clk = ~clk;

  lcd_psave_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .osc_en_o(osc_en_o), .pwr_en_o(pwr_en_o), .duty_en_o(duty_en_o),
    .static_en_o(static_en_o), .force_vdd_o(force_vdd_o), .blank_no(blank_no)
  );

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sb_q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state: mode 0 normal, 1 sleep, 2 standby
  bit       m_disp, m_stat, m_test, m_pend;
  int       m_mode;
  bit [2:0] m_pwr;

  function automatic logic [7:0] outs();
    return {osc_en_o, pwr_en_o, duty_en_o, static_en_o, force_vdd_o, blank_no};
  endfunction

  function automatic logic [7:0] m_outs();
    if (m_mode == 1) return {1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0};
    if (m_mode == 2) return {1'b1, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0};
    return {1'b1, m_pwr, 1'b1, m_stat, 1'b0, 1'b1};
  endfunction

  task automatic m_reset();
    m_disp = 0; m_stat = 0; m_test = 0; m_pend = 0; m_mode = 0; m_pwr = 3'b000;
  endtask

  task automatic m_step(input bit v, input logic [7:0] c);
    if (!v) return;
    if (m_pend) begin m_pend = 0; return; end
    if (m_test) begin
      if (c == 8'hE2 || c == 8'hE3) begin
        m_test = 0;
        if (c == 8'hE2 && m_mode == 2) m_mode = 1;
      end
      return;
    end
    if (c == 8'hAE) m_disp = 0;
    else if (c == 8'hAF) m_disp = 1;
    else if (c == 8'hA5) begin if (!m_disp && m_mode == 0) m_mode = m_stat ? 2 : 1; end
    else if (c == 8'hA4) m_mode = 0;
    else if (c == 8'hAC) begin m_stat = 0; m_pend = 1; end
    else if (c == 8'hAD) begin m_stat = 1; m_pend = 1; end
    else if (c == 8'hE2) begin if (m_mode == 2) m_mode = 1; end
    else if (c == 8'hE3) ;
    else if (c[7:3] == 5'b00101) m_pwr = c[2:0];
    else if (c[7:4] == 4'hF) m_test = 1;
  endtask

  task automatic send(input bit v, input logic [7:0] c, input string req);
    item_t it;
    @(negedge clk);
    cmd_valid_i = v; cmd_i = c;
    m_step(v, c);
    it.exp = m_outs(); it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic check_now(input string req);
    n_vec++;
    if (outs() !== m_outs()) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), m_outs());
    end
  endtask

  // monitor: compare one expected item per clock, mid-cycle
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (outs() !== it.exp) begin
        n_bad++;
        $display("FAIL %s: outputs %b expected %b", it.req, outs(), it.exp);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    #35;
    check_now("R1");
    @(negedge clk); rst_ni = 1'b1;
    send(1, 8'h2F, "R2"); send(1, 8'h2A, "R2"); send(1, 8'h2D, "R2");
    send(0, 8'hAE, "R12"); send(0, 8'h2F, "R12");
    send(1, 8'hAF, "R3"); send(1, 8'hA5, "R3"); send(1, 8'hA4, "R3");
    send(1, 8'hAE, "R3"); send(1, 8'hA5, "R4");
    send(0, 8'hA4, "R12");
    send(1, 8'h2B, "R10"); send(1, 8'hE3, "R4");
    send(1, 8'hA4, "R6");
    send(1, 8'hAD, "R11"); send(1, 8'h00, "R11");
    send(1, 8'hA5, "R5"); send(1, 8'h2C, "R10");
    send(1, 8'hE2, "R7"); send(1, 8'hA4, "R6");
    send(1, 8'hE2, "R7");
    send(1, 8'hAC, "R8"); send(1, 8'hA5, "R8"); send(1, 8'hAD, "R8"); send(1, 8'hF1, "R8");
    send(1, 8'hAC, "R11"); send(1, 8'h2E, "R11");
    send(1, 8'hF3, "R9"); send(1, 8'hA5, "R9"); send(1, 8'h21, "R9"); send(1, 8'hAD, "R9");
    send(1, 8'hE3, "R9"); send(1, 8'hA5, "R9"); send(1, 8'hA4, "R9");
    send(1, 8'hAD, "R9"); send(1, 8'h05, "R9"); send(1, 8'hA5, "R5");
    send(1, 8'hFA, "R9"); send(1, 8'hE2, "R9"); send(1, 8'hA4, "R9");
    send(1, 8'h27, "R2"); send(1, 8'h29, "R2");
    send(0, 8'h00, "R12");
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b0; m_reset();
    #5 check_now("R1");
    @(negedge clk); rst_ni = 1'b1;
    send(1, 8'hA5, "R4"); send(1, 8'hA4, "R6"); send(0, 8'h00, "R12");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule